// File: doc/BRIEF.md
# Three-level bridge PWM modulator

This block turns a signed digital audio sample into the two switching legs of one bridge-tied-load class-D channel. It uses three-level modulation. A carrier counter sets the switching period. Both legs go high together at the start of each period. The positive leg stays high for half a period plus the scaled level, and the negative leg stays high for half a period minus that level. The differential output therefore sits at zero or at one polarity, and that polarity follows the sign of the sample. A zero sample gives two identical square waves in phase. The negative leg is delayed by a fixed, odd number of clock cycles so that the two legs never switch in the same cycle.

The carrier has two sources. In master mode the counter runs freely from the local clock and drives the shared sync pin at twice the switching rate. In slave mode the sync pin is an input. It passes through a two-flop synchronizer, and its rising edges pace the counter, so one carrier period spans two sync periods. A 2-bit gain code scales the sample. The result is saturated so that a few cycles of margin remain at both ends of the period. The level is taken only when a period begins. Mute forces a 50% duty on both legs. The output-enable input controls the tri-state enables of the two legs.

Top module: `btlpwm_mod`

## Requirements
- R1: Take the positive leg delayed by SKEW cycles and compare it with the negative leg. For a level above zero the pair never shows positive low with negative high. For a level below zero it never shows positive high with negative low.
- R2: With a zero level, each leg is high for exactly P/2 of every P cycles (P = 2^CNT_W = 64). The negative leg equals the positive leg delayed by SKEW cycles.
- R3: In master mode, once the mode has been steady for a full period, the two legs never change value in the same clock cycle. SKEW must be odd.
- R4: While mute_i is high when a period starts, both legs run at P/2 high cycles per period, whatever the sample.
- R5: In slave mode sync_oe_o is low. sync_i passes through a two-flop synchronizer. If the sync period Ts is at least P/2 cycles, the positive leg rises once every 2*Ts cycles.
- R6: In master mode sync_oe_o is high, and sync_o has exactly two rising edges in every carrier period of P cycles.
- R7: The gain code multiplies the sample by 10, 20, 32 or 40 for gain_i = 00, 01, 10 and 11. The product is then shifted arithmetically right by PRE_SHIFT = 4, which gives the level v. The positive leg is high P/2+v cycles per period and the negative leg P/2-v.
- R8: During reset both legs and both leg enables are low. One cycle after oe_i is sampled low, pos_oe_o and neg_oe_o are low, and one cycle after it is sampled high, both are high.
- R9: A new level is taken only when a period starts. A sample change in the middle of a period does not alter the current period's duty.
- R10: The level saturates at ±(P/2 - SKEW - 1) = ±28, so no duty ever wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | SAMPLE_W | Signed audio sample, two's complement |
| gain_i | input | 2 | Gain code |
| mute_i | input | 1 | Force 50% duty on both legs |
| oe_i | input | 1 | Leg output enable |
| slave_i | input | 1 | 1 = carrier follows sync_i, 0 = free-running master |
| sync_i | input | 1 | Sync pin input value (slave mode) |
| sync_o | output | 1 | Sync pin output value (master mode), twice the switching rate |
| sync_oe_o | output | 1 | Sync pin drive enable, high in master mode |
| pos_o | output | 1 | Positive leg PWM |
| pos_oe_o | output | 1 | Positive leg tri-state enable |
| neg_o | output | 1 | Negative leg PWM |
| neg_oe_o | output | 1 | Negative leg tri-state enable |

## Verification
The bench sweeps all four gain codes over samples spread from -128 to 127, including both extremes, so that every code reaches saturation at both signs. A design that wraps instead of clamping would show a nearly empty or nearly full duty on the wrong leg. The polarity and same-cycle-edge monitors run on every window. They catch a swapped leg, a missing skew, or a skew that lines up a falling edge of one leg with an edge of the other. Further checks move the sample in the middle of a period, which exposes a level register that loads at once rather than at the period start. Slave runs use sync periods longer than half a period, where a counter that wraps on its own instead of waiting for the sync edge would shorten the period.

// File: rtl/btlpwm_pkg.sv
package btlpwm_pkg;

  typedef enum logic [1:0] {
    GAIN_X10 = 2'b00,
    GAIN_X20 = 2'b01,
    GAIN_X32 = 2'b10,
    GAIN_X40 = 2'b11
  } gain_e;

  localparam int unsigned GAIN_FAC_W = 6;

  // integer multiplier closest to the nominal dB step
  function automatic logic [GAIN_FAC_W-1:0] gain_factor(input gain_e code);
    case (code)
      GAIN_X10: return 6'd10;
      GAIN_X20: return 6'd20;
      GAIN_X32: return 6'd32;
      default:  return 6'd40;
    endcase
  endfunction

endpackage

// File: rtl/btlpwm_carrier.sv
module btlpwm_carrier #(
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned SYNC_FF = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slave_i,
  input  logic             sync_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             start_o,
  output logic             sync_o,
  output logic             sync_oe_o
);

  localparam logic [CNT_W-1:0] ZERO_C      = '0;
  localparam logic [CNT_W-1:0] HALF_C      = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic [CNT_W-1:0] HALF_LAST_C = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [CNT_W-1:0] LAST_C      = '1;

  logic [SYNC_FF:0] sync_q;
  logic             sync_rise;
  logic             half_sel_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sync_oe_q;

  // synchronizer plus one edge-detect stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_FF-1:0], sync_i};
  end

  assign sync_rise = sync_q[SYNC_FF-1] & ~sync_q[SYNC_FF];

  always_comb begin
    if (!slave_i) begin
      cnt_d = cnt_q + 1'b1;
    end else if (sync_rise) begin
      cnt_d = half_sel_q ? HALF_C : ZERO_C;
    end else if (cnt_q == HALF_LAST_C || cnt_q == LAST_C) begin
      cnt_d = cnt_q;  // wait for the next sync edge
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      half_sel_q <= 1'b0;
      sync_oe_q  <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      sync_oe_q  <= ~slave_i;
      if (!slave_i)       half_sel_q <= 1'b0;
      else if (sync_rise) half_sel_q <= ~half_sel_q;
    end
  end

  assign cnt_o     = cnt_q;
  assign start_o   = (cnt_d == ZERO_C);
  assign sync_o    = cnt_q[CNT_W-2];
  assign sync_oe_o = sync_oe_q;

  // R5
  slave_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slave_i && $past(slave_i) && cnt_q == ZERO_C && $past(cnt_q) != ZERO_C)
      |-> $past(sync_rise));

  // R6
  sync_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slave_i |=> sync_oe_o);

  // R5
  slave_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slave_i |=> !sync_oe_o);

endmodule

// File: rtl/btlpwm_level.sv
module btlpwm_level #(
  parameter int unsigned SAMPLE_W  = 8,
  parameter int unsigned CNT_W     = 6,
  parameter int unsigned PRE_SHIFT = 4,
  parameter int          V_MAX     = 28
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic        [1:0]          gain_i,
  input  logic                       mute_i,
  input  logic                       load_i,
  output logic signed [CNT_W:0]      lvl_o
);
  import btlpwm_pkg::*;

  localparam int unsigned PROD_W = SAMPLE_W + GAIN_FAC_W + 1;
  localparam logic signed [PROD_W-1:0] VMAX_P = PROD_W'(V_MAX);
  localparam logic signed [PROD_W-1:0] VMIN_P = -VMAX_P;

  logic signed [GAIN_FAC_W:0] fac_s;
  logic signed [PROD_W-1:0]   prod, scaled;
  logic signed [CNT_W:0]      lvl_d, lvl_q;

  always_comb begin
    fac_s  = $signed({1'b0, gain_factor(gain_e'(gain_i))});
    prod   = PROD_W'(sample_i) * PROD_W'(fac_s);
    scaled = prod >>> PRE_SHIFT;
    if (mute_i)                lvl_d = '0;
    else if (scaled > VMAX_P)  lvl_d = VMAX_P[CNT_W:0];
    else if (scaled < VMIN_P)  lvl_d = VMIN_P[CNT_W:0];
    else                       lvl_d = scaled[CNT_W:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lvl_q <= '0;
    else if (load_i) lvl_q <= lvl_d;
  end

  assign lvl_o = lvl_q;

  // R4
  mute_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && mute_i) |=> lvl_o == 0);

  // R10
  sat_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_o <= V_MAX) && (lvl_o >= -V_MAX));

endmodule

// File: rtl/btlpwm_legs.sv
module btlpwm_legs #(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned SKEW  = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [CNT_W-1:0]      cnt_i,
  input  logic signed [CNT_W:0] lvl_i,
  output logic                  pos_o,
  output logic                  neg_o
);

  localparam logic signed [CNT_W+1:0] HALF_S = {2'b00, 1'b1, {(CNT_W-1){1'b0}}};

  logic signed [CNT_W+1:0] cnt_s, lvl_s, thr_p, thr_n;
  logic                    pos_raw, neg_raw;
  logic                    pos_q;
  logic [SKEW:0]           neg_q;

  always_comb begin
    cnt_s   = $signed({2'b00, cnt_i});
    lvl_s   = {lvl_i[CNT_W], lvl_i};
    thr_p   = HALF_S + lvl_s;
    thr_n   = HALF_S - lvl_s;
    pos_raw = cnt_s < thr_p;
    neg_raw = cnt_s < thr_n;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q    <= 1'b0;
      neg_q[0] <= 1'b0;
    end else begin
      pos_q    <= pos_raw;
      neg_q[0] <= neg_raw;
    end
  end

  // negative leg trails by SKEW extra stages
  for (genvar i = 1; i <= SKEW; i++) begin : g_skew
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) neg_q[i] <= 1'b0;
      else         neg_q[i] <= neg_q[i-1];
    end
  end

  assign pos_o = pos_q;
  assign neg_o = neg_q[SKEW];

  // R1
  pos_polarity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i > 0) |-> !(!pos_raw && neg_raw));

  // R1
  neg_polarity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i < 0) |-> !(pos_raw && !neg_raw));

endmodule

// File: rtl/btlpwm_mod.sv
module btlpwm_mod #(
  parameter int unsigned SAMPLE_W  = 8,
  parameter int unsigned CNT_W     = 6,
  parameter int unsigned SKEW      = 3,  // must be odd
  parameter int unsigned PRE_SHIFT = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [1:0]          gain_i,
  input  logic                mute_i,
  input  logic                oe_i,
  input  logic                slave_i,
  input  logic                sync_i,
  output logic                sync_o,
  output logic                sync_oe_o,
  output logic                pos_o,
  output logic                pos_oe_o,
  output logic                neg_o,
  output logic                neg_oe_o
);

  localparam int          V_MAX   = 2 ** (CNT_W - 1) - int'(SKEW) - 1;
  localparam int unsigned AGE_MAX = 2 ** CNT_W + SKEW + 2;
  localparam int unsigned AGE_W   = $clog2(AGE_MAX + 1);

  logic [CNT_W-1:0]      cnt;
  logic                  start;
  logic signed [CNT_W:0] lvl;
  logic                  oe_q;

  btlpwm_carrier #(
    .CNT_W  (CNT_W),
    .SYNC_FF(2)
  ) u_carrier (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .slave_i  (slave_i),
    .sync_i   (sync_i),
    .cnt_o    (cnt),
    .start_o  (start),
    .sync_o   (sync_o),
    .sync_oe_o(sync_oe_o)
  );

  btlpwm_level #(
    .SAMPLE_W (SAMPLE_W),
    .CNT_W    (CNT_W),
    .PRE_SHIFT(PRE_SHIFT),
    .V_MAX    (V_MAX)
  ) u_level (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sample_i($signed(sample_i)),
    .gain_i  (gain_i),
    .mute_i  (mute_i),
    .load_i  (start),
    .lvl_o   (lvl)
  );

  btlpwm_legs #(
    .CNT_W(CNT_W),
    .SKEW (SKEW)
  ) u_legs (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_i (cnt),
    .lvl_i (lvl),
    .pos_o (pos_o),
    .neg_o (neg_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_q <= 1'b0;
    else         oe_q <= oe_i;
  end

  assign pos_oe_o = oe_q;
  assign neg_oe_o = oe_q;

  // cycles spent steadily in master mode, saturating
  logic [AGE_W-1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          age_q <= '0;
    else if (slave_i)                     age_q <= '0;
    else if (age_q != AGE_W'(AGE_MAX))    age_q <= age_q + 1'b1;
  end

  // R9
  latch_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl != $past(lvl)) |-> (cnt == '0));

  // R8
  oe_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |=> (!pos_oe_o && !neg_oe_o));

  // R3
  edge_apart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == AGE_W'(AGE_MAX)) |-> !((pos_o != $past(pos_o)) && (neg_o != $past(neg_o))));

endmodule

// File: tb/tb_btlpwm_mod.sv
module tb_btlpwm_mod;
  localparam int SAMPLE_W  = 8;
  localparam int CNT_W     = 6;
  localparam int SKEW      = 3;
  localparam int PRE_SHIFT = 4;
  localparam int P         = 2 ** CNT_W;
  localparam int HALF      = P / 2;
  localparam int VMAX      = HALF - SKEW - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [SAMPLE_W-1:0] sample = '0;
  logic [1:0] gain = 2'b00;
  logic mute = 1'b0, oe = 1'b0, slave = 1'b0, sync_in = 1'b0;
  logic sync_o, sync_oe_o, pos_o, pos_oe_o, neg_o, neg_oe_o;

  int total = 0;
  int bad = 0;
  int ts_half = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  btlpwm_mod #(
    .SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W), .SKEW(SKEW), .PRE_SHIFT(PRE_SHIFT)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .gain_i(gain),
    .mute_i(mute), .oe_i(oe), .slave_i(slave), .sync_i(sync_in),
    .sync_o(sync_o), .sync_oe_o(sync_oe_o), .pos_o(pos_o), .pos_oe_o(pos_oe_o),
    .neg_o(neg_o), .neg_oe_o(neg_oe_o)
  );

  // external sync source, half period ts_half cycles
  initial begin
    int gen = 0;
    forever begin
      @(negedge clk);
      if (ts_half > 0) begin
        gen++;
        if (gen >= ts_half) begin sync_in = ~sync_in; gen = 0; end
      end else gen = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int fac(input int g);
    case (g)
      0: return 10;
      1: return 20;
      2: return 32;
      default: return 40;
    endcase
  endfunction

  function automatic int exp_level(input int s, input int g, input bit m);
    int sc;
    if (m) return 0;
    sc = (s * fac(g)) >>> PRE_SHIFT;
    if (sc > VMAX) sc = VMAX;
    if (sc < -VMAX) sc = -VMAX;
    return sc;
  endfunction

  // one master window of P cycles after settling
  task automatic window(input int s, input int g, input bit m);
    logic [15:0] hist;
    logic pp, pn, ps;
    int v, ph, nh, pol, edg, sr;
    string dreq;
    v = exp_level(s, g, m);
    dreq = m ? "R4 mute duty" : ((v == VMAX || v == -VMAX) ? "R7/R10 saturated duty" : "R7 gain duty");
    sample = SAMPLE_W'(s); gain = 2'(g); mute = m;
    repeat (2 * P) @(negedge clk);
    hist = '0; ph = 0; nh = 0; pol = 0; edg = 0; sr = 0;
    pp = pos_o; pn = neg_o; ps = sync_o;
    for (int i = 0; i < SKEW + P; i++) begin
      @(negedge clk);
      hist = {hist[14:0], pos_o};
      if (i >= SKEW) begin
        ph += int'(pos_o);
        nh += int'(neg_o);
        if (v > 0 && !hist[SKEW] && neg_o) pol++;
        if (v < 0 && hist[SKEW] && !neg_o) pol++;
        if (v == 0 && hist[SKEW] != neg_o) pol++;
        if (pos_o != pp && neg_o != pn) edg++;
        if (sync_o && !ps) sr++;
      end
      pp = pos_o; pn = neg_o; ps = sync_o;
    end
    chk(ph == HALF + v, {dreq, " pos"}, ph, HALF + v);
    chk(nh == HALF - v, {dreq, " neg"}, nh, HALF - v);
    chk(pol == 0, (v == 0) ? "R2 in-phase" : "R1 polarity", pol, 0);
    chk(edg == 0, "R3 edge apart", edg, 0);
    chk(sr == 2, "R6 sync rises", sr, 2);
  endtask

  task automatic wait_pos_rise();
    logic pv;
    pv = pos_o;
    for (int i = 0; i < 4 * P + 400; i++) begin
      @(negedge clk);
      if (pos_o && !pv) return;
      pv = pos_o;
    end
  endtask

  initial begin
    int hl, gap;
    logic pv;
    // reset state
    repeat (3) @(negedge clk);
    chk(!pos_o && !neg_o, "R8 reset legs", int'(pos_o) + int'(neg_o), 0);
    chk(!pos_oe_o && !neg_oe_o, "R8 reset enables", int'(pos_oe_o) + int'(neg_oe_o), 0);
    rst_n = 1'b1;
    oe = 1'b1;
    repeat (2) @(negedge clk);
    chk(pos_oe_o && neg_oe_o, "R8 enable on", int'(pos_oe_o) + int'(neg_oe_o), 2);
    chk(sync_oe_o == 1'b1, "R6 sync drives", int'(sync_oe_o), 1);

    // gain sweep, all codes
    for (int g = 0; g < 4; g++)
      for (int k = 0; k <= 16; k++)
        window((k == 16) ? 127 : -128 + 16 * k, g, 1'b0);

    // mute ignores sample
    window(100, 3, 1'b1);
    window(-90, 1, 1'b1);
    window(0, 0, 1'b0);

    // R9: mid-period sample change
    sample = '0; gain = 2'b00; mute = 1'b0;
    repeat (2 * P) @(negedge clk);
    wait_pos_rise();
    hl = 1;
    repeat (4) begin @(negedge clk); hl += int'(pos_o); end
    sample = SAMPLE_W'(40);
    while (pos_o && hl < 2 * P) begin @(negedge clk); if (pos_o) hl++; end
    chk(hl == HALF, "R9 current period kept", hl, HALF);
    wait_pos_rise();
    hl = 1;
    @(negedge clk);
    while (pos_o && hl < 2 * P) begin hl++; @(negedge clk); end
    chk(hl == HALF + 25, "R9 next period new", hl, HALF + 25);

    // output enable off
    oe = 1'b0;
    repeat (2) @(negedge clk);
    chk(!pos_oe_o && !neg_oe_o, "R8 enable off", int'(pos_oe_o) + int'(neg_oe_o), 0);
    oe = 1'b1;

    // slave mode periods
    sample = '0;
    for (int t = 0; t < 3; t++) begin
      int th;
      th = 16 + 4 * t;
      ts_half = th;
      slave = 1'b1;
      repeat (8 * th) @(negedge clk);
      chk(sync_oe_o == 1'b0, "R5 sync input", int'(sync_oe_o), 0);
      wait_pos_rise();
      gap = 0; pv = pos_o;
      for (int i = 0; i < 400; i++) begin
        @(negedge clk); gap++;
        if (pos_o && !pv) break;
        pv = pos_o;
      end
      chk(gap == 4 * th, "R5 slave period", gap, 4 * th);
    end
    slave = 1'b0;
    ts_half = 0;
    window(-60, 2, 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule